// File: doc/BRIEF.md
# Timer Event Interrupt and DMA Routing Controller

This block keeps the interrupt state for a group of timer channels. Each channel produces two compare-match event strobes, called compare A and compare B. For each of these sources the block holds three bits:

- a sticky event flag;
- an interrupt enable;
- a routing bit, which hands the event either to the CPU as an interrupt or to a DMA engine as a one-cycle request strobe.

A routed event keeps the CPU interrupt back until the DMA engine reports completion for that source. After that, the still-set flag can raise the CPU interrupt in the normal way.

Software reaches four registers over a simple register bus: write strobe, 2-bit address and write data, with read data returned combinationally for the current address. A global mode input selects how writes act on the flags and on the routing bits. With the mode at 1, writing a 1 clears a flag and writing a 1 sets a routing bit. With the mode at 0, both registers behave as plain read/write.

Among the pending sources, an arbiter picks the one whose channel priority is highest and compares it against the CPU interrupt level. It drives the request together with the winning channel and event. Every pin is a plain control or status signal. No pin carries a data stream, so no pin has a valid/ready handshake or back-pressure.

Top module: `irq_dma_route`

## Requirements
- R1: After reset, all flags, enables, routing bits, DMA-hold state and priorities are 0, and `irq_req` and `dma_req` are 0. Software should still clear the flags before it enables interrupts.
- R2: An event strobe sets the source's flag on the next clock edge, whatever its enable, routing or priority. Source s = 2*channel + (0 for A, 1 for B) sits at bit s of the flag (address 0), enable (address 1) and routing (address 2) registers.
- R3: Only a software write clears a flag. With `mode_w1c`=1, writing 1 clears the flag and writing 0 leaves it unchanged. With `mode_w1c`=0, writing 0 clears the flag and writing 1 leaves it unchanged (it never sets it).
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: With `mode_w1c`=1, writing 1 to a routing bit sets it and writing 0 leaves it unchanged. With `mode_w1c`=0, the routing bit takes the written value. A routing value of 1 selects DMA.
- R6: An event on a source whose routing bit is 1 pulses `dma_req[s]` for exactly the one cycle after the event. That source gives no CPU interrupt until a `dma_done[s]` pulse arrives. After the pulse, its set flag is eligible again.
- R7: A source is eligible when its flag and enable are set and it is not waiting on DMA. `irq_req` is 1 exactly when the top eligible source's channel priority (address 3, bits [c*PRIO_W +: PRIO_W]) is strictly greater than `cpu_il` and `cpu_ie` is 1.
- R8: The winner is the eligible source with the highest priority value. Ties go to the lowest channel, and within a channel compare A (`irq_evt_b`=0) beats compare B. `irq_ch` and `irq_evt_b` name the winner.
- R9: A flag that stays set keeps `irq_req` asserted on every cycle in which the conditions of R7 hold.
- R10: The enable and priority registers are plain read/write. `bus_rdata` returns the register selected by `bus_addr`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_a | input | NCH | Compare A event strobes, one per channel |
| evt_b | input | NCH | Compare B event strobes, one per channel |
| dma_done | input | 2*NCH | DMA completion pulse per source |
| mode_w1c | input | 1 | 1: write-1-clears flags and set-only routing; 0: plain read/write |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 flags, 1 enables, 2 routing, 3 priorities |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_il | input | PRIO_W | Current CPU interrupt level |
| irq_req | output | 1 | CPU interrupt request |
| irq_ch | output | CH_W | Winning channel |
| irq_evt_b | output | 1 | Winning event: 0 compare A, 1 compare B |
| dma_req | output | 2*NCH | One-cycle DMA request strobe per source |

## Verification
The embedded assertions check the following on every cycle:

- an event always leaves its flag set;
- a clear flag never sets without an event;
- in set-only mode a routing bit never drops;
- the DMA hold persists until completion;
- a routed event always produces its strobe;
- any asserted request names an eligible source while the global enable is on, with a priority above the CPU level.

Only the bench's scenarios can show the choices between values:

- the winner among tied and untied priorities;
- the two clearing methods applied to mixed write patterns;
- the event-against-clear collision;
- the interrupt that appears only after DMA completion.

The bench's cycle model checks these against every output on every clock.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  typedef enum logic [1:0] {
    SEL_FLAG  = 2'd0,
    SEL_EN    = 2'd1,
    SEL_ROUTE = 2'd2,
    SEL_PRIO  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqr_src_cell.sv
module irqr_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic dma_done,
  input  logic mode_w1c,
  input  logic wr_flag,
  input  logic wr_route,
  input  logic wbit,
  output logic flag,
  output logic route,
  output logic held,
  output logic dma_req
);
  logic flag_d, route_d, held_d;

  always_comb begin
    flag_d = flag;
    if (wr_flag) flag_d = mode_w1c ? (flag & ~wbit) : (flag & wbit);
    if (evt) flag_d = 1'b1;          // set beats clear
    route_d = route;
    if (wr_route) route_d = mode_w1c ? (route | wbit) : wbit;
    held_d = held;
    if (dma_done) held_d = 1'b0;
    if (evt) held_d = route;         // new event re-arms the hold per routing
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      route   <= 1'b0;
      held    <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      flag    <= flag_d;
      route   <= route_d;
      held    <= held_d;
      dma_req <= evt & route;
    end
  end

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !evt) |=> !flag);
  // R5
  route_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route && mode_w1c) |=> route);
  // R6
  dma_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && route) |=> dma_req);
  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !evt && !dma_done) |=> held);
endmodule

// File: rtl/irqr_arbiter.sv
module irqr_arbiter #(
  parameter int NCH    = 4,
  parameter int PRIO_W = 3,
  localparam int NSRC  = 2 * NCH,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NSRC-1:0]       elig,
  input  logic [NCH*PRIO_W-1:0] prio,
  input  logic                  cpu_ie,
  input  logic [PRIO_W-1:0]     cpu_il,
  output logic                  req,
  output logic [CH_W-1:0]       win_ch,
  output logic                  win_b
);
  logic              found;
  logic [PRIO_W-1:0] best;

  always_comb begin
    found  = 1'b0;
    best   = '0;
    win_ch = '0;
    win_b  = 1'b0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (!found || prio[(s/2)*PRIO_W +: PRIO_W] > best)) begin
        found  = 1'b1;
        best   = prio[(s/2)*PRIO_W +: PRIO_W];
        win_ch = CH_W'(s / 2);
        win_b  = (s % 2) == 1;
      end
    end
    req = found && cpu_ie && (best > cpu_il);
  end
endmodule

// File: rtl/irq_dma_route.sv
module irq_dma_route #(
  parameter int NCH    = 4,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  localparam int NSRC  = 2 * NCH,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        evt_a,
  input  logic [NCH-1:0]        evt_b,
  input  logic [NSRC-1:0]       dma_done,
  input  logic                  mode_w1c,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  cpu_ie,
  input  logic [PRIO_W-1:0]     cpu_il,
  output logic                  irq_req,
  output logic [CH_W-1:0]       irq_ch,
  output logic                  irq_evt_b,
  output logic [NSRC-1:0]       dma_req
);
  import irqr_pkg::*;

  logic [NSRC-1:0]       flags, routes, helds, enables, elig;
  logic [NCH*PRIO_W-1:0] prios;
  logic                  wr_flag, wr_route;
  reg_sel_e              sel;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_flag  = bus_wr && (sel == SEL_FLAG);
  assign wr_route = bus_wr && (sel == SEL_ROUTE);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic ev;
    if (s % 2 == 0) begin : g_a
      assign ev = evt_a[s/2];
    end else begin : g_b
      assign ev = evt_b[s/2];
    end
    irqr_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .evt(ev), .dma_done(dma_done[s]),
      .mode_w1c(mode_w1c), .wr_flag(wr_flag), .wr_route(wr_route),
      .wbit(bus_wdata[s]), .flag(flags[s]), .route(routes[s]),
      .held(helds[s]), .dma_req(dma_req[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enables <= '0;
      prios   <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_EN)   enables <= bus_wdata[NSRC-1:0];
      if (sel == SEL_PRIO) prios   <= bus_wdata[NCH*PRIO_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_FLAG:  bus_rdata[NSRC-1:0]       = flags;
      SEL_EN:    bus_rdata[NSRC-1:0]       = enables;
      SEL_ROUTE: bus_rdata[NSRC-1:0]       = routes;
      default:   bus_rdata[NCH*PRIO_W-1:0] = prios;
    endcase
  end

  assign elig = flags & enables & ~helds;

  irqr_arbiter #(.NCH(NCH), .PRIO_W(PRIO_W)) u_arb (
    .elig(elig), .prio(prios), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
    .req(irq_req), .win_ch(irq_ch), .win_b(irq_evt_b)
  );

  // R7
  req_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cpu_ie);
  // R7
  req_above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (prios[int'(irq_ch)*PRIO_W +: PRIO_W] > cpu_il));
  // R8
  winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flags[int'(irq_ch)*2 + int'(irq_evt_b)]
                 && enables[int'(irq_ch)*2 + int'(irq_evt_b)]
                 && !helds[int'(irq_ch)*2 + int'(irq_evt_b)]));
endmodule

// File: tb/irq_dma_route_tb.sv
module irq_dma_route_tb;
  localparam int NCH = 4, PRIO_W = 3, DATA_W = 32, NSRC = 8, CH_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] evt_a = '0, evt_b = '0;
  logic [NSRC-1:0] dma_done = '0;
  logic mode_w1c = 1'b1, bus_wr = 1'b0, cpu_ie = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic [PRIO_W-1:0] cpu_il = '0;
  logic irq_req, irq_evt_b;
  logic [CH_W-1:0] irq_ch;
  logic [NSRC-1:0] dma_req;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_dma_route u_dut (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b), .dma_done(dma_done),
    .mode_w1c(mode_w1c), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_ie(cpu_ie), .cpu_il(cpu_il), .irq_req(irq_req),
    .irq_ch(irq_ch), .irq_evt_b(irq_evt_b), .dma_req(dma_req)
  );

  // behavioural reference state
  bit m_flag[NSRC], m_en[NSRC], m_route[NSRC], m_held[NSRC], m_dma[NSRC];
  int m_prio[NCH];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint pack(input int which);
    longint v = 0;
    for (int s = 0; s < NSRC; s++) begin
      if (which == 0 && m_flag[s])  v |= (64'd1 << s);
      if (which == 1 && m_en[s])    v |= (64'd1 << s);
      if (which == 2 && m_route[s]) v |= (64'd1 << s);
      if (which == 4 && m_dma[s])   v |= (64'd1 << s);
    end
    if (which == 3) for (int c = 0; c < NCH; c++) v |= longint'(m_prio[c]) << (c * PRIO_W);
    return v;
  endfunction

  task automatic compare_all();
    int win = -1;
    bit exp_req;
    // scan from highest priority level down; first hit in index order wins
    for (int p = (1 << PRIO_W) - 1; p >= 0 && win < 0; p--)
      for (int s = 0; s < NSRC && win < 0; s++)
        if (m_flag[s] && m_en[s] && !m_held[s] && m_prio[s/2] == p) win = s;
    exp_req = (win >= 0) && cpu_ie && (m_prio[win/2] > int'(cpu_il));
    chk(irq_req == exp_req, "R7 model irq_req", irq_req, exp_req);
    if (exp_req) chk(int'(irq_ch) * 2 + int'(irq_evt_b) == win, "R8 model winner",
                     int'(irq_ch) * 2 + int'(irq_evt_b), win);
    chk(dma_req == NSRC'(pack(4)), "R6 model dma_req", dma_req, pack(4));
    chk(bus_rdata == DATA_W'(pack(int'(bus_addr))), "R10 model rdata", bus_rdata, pack(int'(bus_addr)));
  endtask

  task automatic model_step();
    bit nf[NSRC], nh[NSRC], nr[NSRC], nd[NSRC];
    for (int s = 0; s < NSRC; s++) begin
      bit e = (s % 2) ? evt_b[s/2] : evt_a[s/2];
      bit w = bus_wdata[s];
      nf[s] = m_flag[s]; nh[s] = m_held[s]; nr[s] = m_route[s];
      if (bus_wr && bus_addr == 0) nf[s] = mode_w1c ? (m_flag[s] && !w) : (m_flag[s] && w);
      if (bus_wr && bus_addr == 2) nr[s] = mode_w1c ? (m_route[s] || w) : w;
      if (dma_done[s]) nh[s] = 1'b0;
      if (e) begin nf[s] = 1'b1; nh[s] = m_route[s]; end
      nd[s] = e && m_route[s];
    end
    if (bus_wr && bus_addr == 1) for (int s = 0; s < NSRC; s++) m_en[s] = bus_wdata[s];
    if (bus_wr && bus_addr == 3)
      for (int c = 0; c < NCH; c++) m_prio[c] = int'(bus_wdata[c*PRIO_W +: PRIO_W]);
    for (int s = 0; s < NSRC; s++) begin
      m_flag[s] = nf[s]; m_held[s] = nh[s]; m_route[s] = nr[s]; m_dma[s] = nd[s];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    #1;
    if (rst_n) compare_all();
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 2'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, input longint exp, input string req);
    bus_addr = 2'(a);
    #1;
    chk(bus_rdata == DATA_W'(exp), req, bus_rdata, exp);
  endtask

  task automatic irq_is(input bit r, input int ch, input bit b, input string req);
    #1;
    chk(irq_req == r, req, irq_req, r);
    if (r) chk(int'(irq_ch) == ch && irq_evt_b == b, req, int'(irq_ch) * 2 + int'(irq_evt_b), ch * 2 + int'(b));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSRC; s++) begin
      m_flag[s] = 0; m_en[s] = 0; m_route[s] = 0; m_held[s] = 0; m_dma[s] = 0;
    end
    for (int c = 0; c < NCH; c++) m_prio[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(0, 0, "R1 flags after reset");
    rd(2, 0, "R1 routing after reset");
    rd(3, 0, "R1 priorities after reset");
    chk(irq_req == 0 && dma_req == 0, "R1 outputs after reset", {irq_req, dma_req}, 0);

    cpu_ie = 1; cpu_il = 2; mode_w1c = 1;
    wr(1, 'hFF);
    rd(1, 'hFF, "R10 enable readback");
    wr(3, 3 | (5 << 3) | (5 << 6) | (7 << 9));
    rd(3, 3 | (5 << 3) | (5 << 6) | (7 << 9), "R10 priority readback");

    // R2 / R7: event on channel 1 compare A
    evt_a[1] = 1; tick(); evt_a = '0;
    rd(0, 'h04, "R2 flag set by event");
    irq_is(1, 1, 0, "R7 irq for ch1 A");
    tick();
    irq_is(1, 1, 0, "R9 irq persists while flag set");

    // R3 write-1-clear mode
    wr(0, 0);
    rd(0, 'h04, "R3 w1c write 0 keeps flag");
    wr(0, 'h04);
    rd(0, 0, "R3 w1c write 1 clears flag");
    irq_is(0, 0, 0, "R3 irq drops after clear");

    // R8 tie: ch1 B vs ch2 A, both priority 5
    evt_b[1] = 1; evt_a[2] = 1; tick(); evt_b = '0; evt_a = '0;
    rd(0, 'h18, "R2 two flags");
    irq_is(1, 1, 1, "R8 tie goes to lower channel");
    evt_a[3] = 1; tick(); evt_a = '0;
    irq_is(1, 3, 0, "R8 highest priority wins");
    cpu_il = 7; tick();
    irq_is(0, 0, 0, "R7 level not exceeded");
    cpu_il = 2; cpu_ie = 0; tick();
    irq_is(0, 0, 0, "R7 global enable off");
    cpu_ie = 1;

    // R3 read/write mode
    mode_w1c = 0;
    wr(0, 'h41);
    rd(0, 'h40, "R3 rw mode: 0 clears, 1 never sets");
    wr(0, 0);
    rd(0, 0, "R3 rw mode clear all");

    // R4 event against clear
    evt_a[0] = 1; tick(); evt_a = '0;
    evt_a[0] = 1; wr(0, 0); evt_a = '0;
    rd(0, 'h01, "R4 set wins over clear");
    wr(0, 0);

    // R7 enable masking
    wr(1, 0);
    evt_a[3] = 1; tick(); evt_a = '0;
    rd(0, 'h40, "R2 flag set while disabled");
    irq_is(0, 0, 0, "R7 disabled source silent");
    wr(1, 'hFF);
    irq_is(1, 3, 0, "R7 enable releases irq");
    wr(0, 0);

    // R5 routing write modes
    mode_w1c = 1;
    wr(2, 'h01); rd(2, 'h01, "R5 set-only write 1");
    wr(2, 'h00); rd(2, 'h01, "R5 set-only write 0 ignored");
    mode_w1c = 0;
    wr(2, 'h02); rd(2, 'h02, "R5 rw mode takes value");
    wr(2, 'h01); rd(2, 'h01, "R5 rw mode reselect");

    // R6 routed event on channel 0 compare A (priority 3 > level 2)
    evt_a[0] = 1; tick(); evt_a = '0;
    chk(dma_req == 8'h01, "R6 dma strobe", dma_req, 1);
    irq_is(0, 0, 0, "R6 irq held while routed");
    tick();
    chk(dma_req == 0, "R6 strobe one cycle", dma_req, 0);
    irq_is(0, 0, 0, "R6 still held before done");
    dma_done[0] = 1; tick(); dma_done = '0;
    irq_is(1, 0, 0, "R6 irq after dma done");
    wr(0, 0);
    irq_is(0, 0, 0, "R3 clear after dma");
    repeat (3) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule